// File: doc/BRIEF.md
# Integer Condition Flag Generator

This block produces the five integer condition flags (extend, negative, zero, overflow, carry) that follow an integer ALU operation, and holds them in a register. The ALU datapath supplies the two operands, the result it computed, an operation class and an operand size. The block looks only at the bits inside the selected size. It derives the sign, zero, overflow and carry/borrow flags from the most significant bits of the operands and the result. Each flag is then updated, cleared or held as the operation class requires.

The extend flag is kept apart from carry. It follows carry only after add and subtract. Logical, move and compare operations leave it as it was. Compare works like subtract for the other four flags, so a compare and the matching subtract give identical N, Z, V and C. The registered flags are presented as the low byte of a status word, with the three upper bits tied to zero.

Top module: `ccr_flag_unit`

## Requirements
- R1: `ccr_out` carries X at bit 4, N at bit 3, Z at bit 2, V at bit 1 and C at bit 0; bits 7 to 5 are always zero.
- R2: Operand size is encoded 2'b00 byte, 2'b01 word, 2'b10 long; N equals result bit 7, 15 or 31 respectively.
- R3: Z is set exactly when result bits [7:0], [15:0] or [31:0] (by size) are all zero; result bits above the size have no effect.
- R4: For op class 3'b000 (add, result = dst + src), C is the carry out of the top bit of the size and V is set on signed overflow.
- R5: For op class 3'b001 (subtract, result = dst - src), C is the borrow out of the top bit of the size and V is set on signed overflow.
- R6: After add or subtract, X equals the new C.
- R7: For op classes 3'b010 (logical) and 3'b011 (move), V and C are cleared, X is kept, and N and Z follow the result.
- R8: For op class 3'b100 (compare), N, Z, V and C are set as for subtract and X is kept.
- R9: The flags are unchanged when `upd_valid` is low, when the op class is 3'b101 to 3'b111, or when the size code is 2'b11.
- R10: Flags are written on the rising clock edge where `upd_valid` is high and appear on `ccr_out` after that edge; a synchronous `rst` clears all five flags and takes priority over an update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| upd_valid | input | 1 | Strobe: write flags this cycle |
| op_class | input | 3 | Operation class code |
| op_size | input | 2 | Operand size code |
| opnd_src | input | 32 | Source operand |
| opnd_dst | input | 32 | Destination operand |
| alu_res | input | 32 | ALU result |
| ccr_out | output | 8 | Registered flags, low status byte |

## Verification
The bench targets results whose upper bits are non-zero while the sized part is zero or negative. A design that reads the wrong width would miss Z or take N from the wrong bit. It drives signed overflow and borrow at all three sizes, where swapped add and subtract formulas would flip V or C. Runs of logical, move and compare operations follow arithmetic ones so that X must survive them; a design that copies C into X on every update would lose the earlier extend value. Reserved op and size codes, a dropped strobe, and a reset asserted together with a valid update must all leave the flags held or cleared, not rewritten.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    localparam int DATA_W    = 32;
    localparam int NUM_SIZES = 3;

    typedef enum logic [2:0] {
        OP_ADD   = 3'b000,
        OP_SUB   = 3'b001,
        OP_LOGIC = 3'b010,
        OP_MOVE  = 3'b011,
        OP_CMP   = 3'b100
    } op_class_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10
    } op_size_e;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

endpackage

// File: rtl/ccr_size_view.sv
// Reports the sign bit and the all-zero condition of a value at the selected size.
module ccr_size_view
    import ccr_pkg::*;
#(
    parameter int WIDTH  = DATA_W,
    parameter int NSIZES = NUM_SIZES
) (
    input  logic [WIDTH-1:0] value,
    input  logic [1:0]       size_sel,
    output logic             top_bit,
    output logic             is_zero
);
    logic [NSIZES-1:0] msb_vec;
    logic [NSIZES-1:0] zero_vec;

    for (genvar g = 0; g < NSIZES; g++) begin : g_size
        localparam int SW = 8 << g;
        assign msb_vec[g]  = value[SW-1];
        assign zero_vec[g] = ~|value[SW-1:0];
    end

    always_comb begin
        top_bit = 1'b0;
        is_zero = 1'b0;
        for (int i = 0; i < NSIZES; i++) begin
            if (int'(size_sel) == i) begin
                top_bit = msb_vec[i];
                is_zero = zero_vec[i];
            end
        end
    end
endmodule

// File: rtl/ccr_arith_vc.sv
// Overflow and carry/borrow from the sign bits of operands and result.
module ccr_arith_vc (
    input  logic is_sub,
    input  logic s_msb,
    input  logic d_msb,
    input  logic r_msb,
    output logic ovf,
    output logic cry
);
    always_comb begin
        if (is_sub) begin
            ovf = (~s_msb & d_msb & ~r_msb) | (s_msb & ~d_msb & r_msb);
            cry = (s_msb & ~d_msb) | (r_msb & ~d_msb) | (s_msb & r_msb);
        end else begin
            ovf = (s_msb & d_msb & ~r_msb) | (~s_msb & ~d_msb & r_msb);
            cry = (s_msb & d_msb) | (~r_msb & (s_msb | d_msb));
        end
    end
endmodule

// File: rtl/ccr_flag_unit.sv
module ccr_flag_unit
    import ccr_pkg::*;
#(
    parameter int WIDTH = DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_valid,
    input  logic [2:0]       op_class,
    input  logic [1:0]       op_size,
    input  logic [WIDTH-1:0] opnd_src,
    input  logic [WIDTH-1:0] opnd_dst,
    input  logic [WIDTH-1:0] alu_res,
    output logic [7:0]       ccr_out
);
    localparam int PAD_W = 8 - $bits(flags_t);

    flags_t flags_d, flags_q;

    logic s_msb, d_msb, r_msb;
    logic s_zero_unused, d_zero_unused, r_zero;
    logic ar_v, ar_c;
    logic is_sub_like;

    ccr_size_view #(.WIDTH(WIDTH)) u_src_view (
        .value(opnd_src), .size_sel(op_size), .top_bit(s_msb), .is_zero(s_zero_unused)
    );
    ccr_size_view #(.WIDTH(WIDTH)) u_dst_view (
        .value(opnd_dst), .size_sel(op_size), .top_bit(d_msb), .is_zero(d_zero_unused)
    );
    ccr_size_view #(.WIDTH(WIDTH)) u_res_view (
        .value(alu_res), .size_sel(op_size), .top_bit(r_msb), .is_zero(r_zero)
    );

    assign is_sub_like = (op_class == OP_SUB) || (op_class == OP_CMP);

    ccr_arith_vc u_arith (
        .is_sub(is_sub_like), .s_msb(s_msb), .d_msb(d_msb), .r_msb(r_msb),
        .ovf(ar_v), .cry(ar_c)
    );

    always_comb begin
        flags_d = flags_q;
        if (upd_valid && (op_size != 2'b11)) begin
            case (op_class)
                OP_ADD, OP_SUB: begin
                    flags_d.n = r_msb;
                    flags_d.z = r_zero;
                    flags_d.v = ar_v;
                    flags_d.c = ar_c;
                    flags_d.x = ar_c;
                end
                OP_CMP: begin
                    flags_d.n = r_msb;
                    flags_d.z = r_zero;
                    flags_d.v = ar_v;
                    flags_d.c = ar_c;
                end
                OP_LOGIC, OP_MOVE: begin
                    flags_d.n = r_msb;
                    flags_d.z = r_zero;
                    flags_d.v = 1'b0;
                    flags_d.c = 1'b0;
                end
                default: flags_d = flags_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    assign ccr_out = {{PAD_W{1'b0}}, flags_q};

    // R10: reset clears the flags on the next edge
    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (ccr_out[4:0] == 5'b0));

    // R9: no strobe means no change
    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> $stable(ccr_out));

    // R6: extend follows carry after arithmetic
    assert_x_tracks_c_R6: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && op_size != 2'b11 && (op_class == OP_ADD || op_class == OP_SUB))
        |=> (ccr_out[4] == ccr_out[0]));

    // R7, R8: extend kept on logical, move and compare
    assert_x_kept_R7: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && (op_class == OP_LOGIC || op_class == OP_MOVE || op_class == OP_CMP))
        |=> $stable(ccr_out[4]));

    // R7: logical and move clear V and C
    assert_vc_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && op_size != 2'b11 && (op_class == OP_LOGIC || op_class == OP_MOVE))
        |=> (ccr_out[1:0] == 2'b00));

    // R3, R2: a zero result cannot also be negative
    assert_zn_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        !(ccr_out[3] && ccr_out[2]));

    // R1: pad bits stay zero
    always_comb begin
        assert_pad_zero_R1: assert (ccr_out[7:5] == 3'b000);
    end
endmodule

// File: tb/ccr_flag_unit_tb_top.sv
module ccr_flag_unit_tb_top;
    import ccr_pkg::*;

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  sz;
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] res;
        logic [4:0]  exp;   // X N Z V C
    } vec_t;

    localparam int NV = 13;
    localparam vec_t [0:NV-1] VECS = '{
        '{op:3'b000, sz:2'b00, src:32'h01,       dst:32'h7F,       res:32'h80,       exp:5'b01010}, // R4 byte ovf
        '{op:3'b000, sz:2'b00, src:32'h01,       dst:32'hFF,       res:32'h100,      exp:5'b10101}, // R4 R3 R6 carry, zero
        '{op:3'b010, sz:2'b01, src:32'h0,        dst:32'h0,        res:32'h8000,     exp:5'b11000}, // R7 X kept
        '{op:3'b011, sz:2'b10, src:32'h0,        dst:32'h0,        res:32'h0,        exp:5'b10100}, // R7 move zero
        '{op:3'b001, sz:2'b01, src:32'h1,        dst:32'h0,        res:32'hFFFF,     exp:5'b11001}, // R5 borrow
        '{op:3'b001, sz:2'b10, src:32'h1,        dst:32'h80000000, res:32'h7FFFFFFF, exp:5'b00010}, // R5 ovf
        '{op:3'b100, sz:2'b00, src:32'h20,       dst:32'h10,       res:32'hF0,       exp:5'b01001}, // R8 X kept
        '{op:3'b000, sz:2'b10, src:32'h80000000, dst:32'h80000000, res:32'h0,        exp:5'b10111}, // R4 long
        '{op:3'b100, sz:2'b10, src:32'h5,        dst:32'h5,        res:32'h0,        exp:5'b10100}, // R8 equal
        '{op:3'b001, sz:2'b00, src:32'h1,        dst:32'h80,       res:32'h7F,       exp:5'b00010}, // R5 byte ovf
        '{op:3'b000, sz:2'b01, src:32'h7FFF,     dst:32'h7FFF,     res:32'hFFFE,     exp:5'b01010}, // R4 word
        '{op:3'b010, sz:2'b00, src:32'h0,        dst:32'h0,        res:32'hFFFFFF00, exp:5'b00100}, // R3 upper ignored
        '{op:3'b011, sz:2'b01, src:32'h0,        dst:32'h0,        res:32'h00018000, exp:5'b01000}  // R2 word msb
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        upd_valid;
    logic [2:0]  op_class;
    logic [1:0]  op_size;
    logic [31:0] opnd_src, opnd_dst, alu_res;
    logic [7:0]  ccr_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ccr_flag_unit dut_i (
        .clk(clk), .rst(rst), .upd_valid(upd_valid), .op_class(op_class),
        .op_size(op_size), .opnd_src(opnd_src), .opnd_dst(opnd_dst),
        .alu_res(alu_res), .ccr_out(ccr_out)
    );

    task automatic check(input string req, input logic [7:0] expv);
        checks++;
        if (ccr_out !== expv) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, ccr_out, expv);
        end
    endtask

    // Drive at the falling edge, let one rising edge pass, sample at the next falling edge.
    task automatic apply(input logic v, input logic [2:0] op, input logic [1:0] sz,
                         input logic [31:0] s, input logic [31:0] d, input logic [31:0] r);
        upd_valid = v; op_class = op; op_size = sz;
        opnd_src = s; opnd_dst = d; alu_res = r;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    initial begin
        rst = 1'b1; upd_valid = 1'b1; op_class = 3'b000; op_size = 2'b00;
        opnd_src = 32'h1; opnd_dst = 32'hFF; alu_res = 32'h100;
        repeat (3) @(negedge clk);
        check("R10 reset state with valid high", 8'h00);
        check("R1 pad bits", 8'h00);
        rst = 1'b0;
        upd_valid = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(1'b1, VECS[i].op, VECS[i].sz, VECS[i].src, VECS[i].dst, VECS[i].res);
            check($sformatf("R1-vector %0d", i), {3'b000, VECS[i].exp});
        end
        // state now 01000

        apply(1'b0, 3'b000, 2'b00, 32'h1, 32'hFF, 32'h100);
        check("R9 strobe low holds", 8'b0000_1000);
        apply(1'b1, 3'b101, 2'b00, 32'h1, 32'hFF, 32'h100);
        check("R9 reserved op holds", 8'b0000_1000);
        apply(1'b1, 3'b000, 2'b11, 32'h1, 32'hFF, 32'h100);
        check("R9 reserved size holds", 8'b0000_1000);
        apply(1'b1, 3'b001, 2'b00, 32'h1, 32'h0, 32'hFF);
        check("R6 sub sets X with C", 8'b0001_1001);
        apply(1'b1, 3'b010, 2'b10, 32'h0, 32'h0, 32'h8000_0000);
        check("R7 R2 long msb, X held", 8'b0001_1000);

        rst = 1'b1; upd_valid = 1'b1; op_class = 3'b000; op_size = 2'b00;
        opnd_src = 32'h1; opnd_dst = 32'hFF; alu_res = 32'h100;
        @(negedge clk);
        check("R10 reset mid-run", 8'h00);
        rst = 1'b0; upd_valid = 1'b0;
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule